// File: doc/BRIEF.md
# Dual-Bank Address Remapper

This block sits between a bus master and a nonvolatile memory array built from two equal banks. It translates each request address into a bank select and an offset within that bank. A memory window of `WIN_BYTES` bytes starts at `BASE_ADDR`, which is also where the processor fetches its reset vector. A request outside that window is refused with an error and never reaches the array.

Two configuration bits, dual-bank mode and bank swap, come from the stored settings on `cfg_dual_i` and `cfg_swap_i`. The block captures them only while the synchronous reset is held. After reset they stay fixed until the next reset. In single-bank mode the window is one linear region that spans both banks. In dual-bank mode the window splits at its midpoint. With swap clear, bank 1 sits at the base. With swap set, bank 2 sits at the base and bank 1 moves to the upper half.

Software may post one swap request per session. The request updates `next_swap_o`, which the surrounding system stores and presents back on `cfg_swap_i` at the next reset. The active mapping therefore never moves while the system is running.

Top module: `dbank_remap`

## Requirements
- R1: While `rst_n` is low, `stat_dual_o` and `stat_swap_o` follow `cfg_dual_i` and `cfg_swap_i` one clock later. After reset is released they hold those values, and later changes on the cfg inputs affect neither the status outputs nor the mapping.
- R2: A request whose address lies outside `[BASE_ADDR, BASE_ADDR+WIN_BYTES)` raises `req_err_o`, keeps `mem_valid_o` low and sees `req_ready_o` high in the same cycle.
- R3: In single-bank mode (`stat_dual_o`=0), `mem_bank_o` equals address bit `WIN_W-1` of the window-relative address. The latched swap bit has no effect.
- R4: In dual-bank mode with swap clear, the lower half maps to bank 1 (`mem_bank_o`=0) and the upper half maps to bank 2 (`mem_bank_o`=1).
- R5: In dual-bank mode with swap set, the lower half maps to bank 2 (`mem_bank_o`=1) and the upper half maps to bank 1 (`mem_bank_o`=0).
- R6: `mem_offset_o` is the window-relative address modulo half the window size, so an offset runs from 0 to `WIN_BYTES/2-1`.
- R7: A swap request with `swreq_sel_i`=2'b01 sets `next_swap_o` to 1, and 2'b00 sets it to 0, starting the cycle after the write. The values 2'b10 and 2'b11 are ignored and do not use up the write. No accepted request changes the mapping in force.
- R8: Only the first accepted swap request between resets takes effect, and later ones are ignored. A reset restores the right to write. After reset, `next_swap_o` equals the latched swap bit.
- R9: For an in-window request, `mem_valid_o` is high and `req_ready_o` equals `mem_ready_i`. While reset is held, and in the first cycle after it, `mem_valid_o`, `req_ready_o` and `req_err_o` are low.
- R10: Presenting `next_swap_o` back on `cfg_swap_i` across a reset makes the requested bank the one mapped at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; cfg bits are captured while it is low |
| cfg_dual_i | input | 1 | Stored dual-bank mode setting |
| cfg_swap_i | input | 1 | Stored swap setting |
| req_valid_i | input | 1 | Master request valid |
| req_addr_i | input | AW | Master byte address |
| req_ready_o | output | 1 | Request accepted (or refused) this cycle |
| req_err_o | output | 1 | Error response for an out-of-window address |
| mem_valid_o | output | 1 | Access forwarded to the array |
| mem_bank_o | output | 1 | Physical bank: 0 = bank 1, 1 = bank 2 |
| mem_offset_o | output | WIN_W-1 | Byte offset inside the selected bank |
| mem_ready_i | input | 1 | Array ready |
| swreq_valid_i | input | 1 | Swap request write strobe |
| swreq_sel_i | input | 2 | Requested boot bank code |
| next_swap_o | output | 1 | Swap value to be loaded at the next reset |
| stat_dual_o | output | 1 | Latched dual-bank mode |
| stat_swap_o | output | 1 | Latched swap state |

## Verification
The bench probes the exact edges of the window: the first byte, the last word, one word below the base and the first byte past the end. A design with an off-by-one window check would either forward a stray access or refuse a legal one. It also probes both sides of the midpoint in all three mapping states. A design that applied swap in single-bank mode, or inverted the half select, would route the reset vector to the wrong bank. It changes the cfg inputs after reset and posts several swap requests in one session, including reserved codes. A latch that stayed open, or a request register that could be rewritten, would then show up as a moving mapping or a changed `next_swap_o`. A final reset fed from `next_swap_o` checks that the requested bank really reaches the base.

// File: rtl/dbank_remap.sv
module dbank_remap #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h0800_0000,
  parameter int WIN_BYTES = 524288,
  localparam int WIN_W = $clog2(WIN_BYTES),
  localparam int OW = WIN_W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual_i,
  input  logic          cfg_swap_i,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          req_ready_o,
  output logic          req_err_o,
  output logic          mem_valid_o,
  output logic          mem_bank_o,
  output logic [OW-1:0] mem_offset_o,
  input  logic          mem_ready_i,
  input  logic          swreq_valid_i,
  input  logic [1:0]    swreq_sel_i,
  output logic          next_swap_o,
  output logic          stat_dual_o,
  output logic          stat_swap_o
);

  logic dual_q, swap_q, live_q, used_q, pend_q;
  logic in_win, upper, sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dual_q <= cfg_dual_i;
      swap_q <= cfg_swap_i;
      live_q <= 1'b0;
      used_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (swreq_valid_i && sel_ok && !used_q) begin
        used_q <= 1'b1;
        pend_q <= swreq_sel_i[0];
      end
    end
  end

  assign sel_ok = (swreq_sel_i[1] == 1'b0);
  assign in_win = (req_addr_i[AW-1:WIN_W] == BASE_ADDR[AW-1:WIN_W]);
  assign upper  = req_addr_i[WIN_W-1];

  assign mem_valid_o  = live_q && req_valid_i && in_win;
  assign req_err_o    = live_q && req_valid_i && !in_win;
  assign req_ready_o  = live_q && (in_win ? mem_ready_i : 1'b1);
  assign mem_bank_o   = dual_q ? (upper ^ swap_q) : upper;
  assign mem_offset_o = req_addr_i[OW-1:0];

  assign next_swap_o = used_q ? pend_q : swap_q;
  assign stat_dual_o = dual_q;
  assign stat_swap_o = swap_q;

endmodule

module dbank_remap_chk #(
  parameter int AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 32'h0800_0000,
  parameter int WIN_BYTES = 524288,
  localparam int WIN_W = $clog2(WIN_BYTES),
  localparam int OW = WIN_W - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic [AW-1:0] req_addr_i,
  input logic          req_ready_o,
  input logic          req_err_o,
  input logic          mem_valid_o,
  input logic          mem_bank_o,
  input logic [OW-1:0] mem_offset_o,
  input logic          mem_ready_i,
  input logic          next_swap_o,
  input logic          stat_dual_o,
  input logic          stat_swap_o
);

  logic up_q, seen_q, prev_q;
  logic outside;

  assign outside = (req_addr_i < BASE_ADDR) || (req_addr_i >= BASE_ADDR + AW'(WIN_BYTES));

  always_ff @(posedge clk) begin
    prev_q <= next_swap_o;
    if (!rst_n) begin
      up_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      up_q <= 1'b1;
      if (next_swap_o != prev_q) seen_q <= 1'b1;
    end
  end

  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(stat_dual_o) && $stable(stat_swap_o)));

  a_r2_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && req_valid_i && outside) |-> (req_err_o && !mem_valid_o && req_ready_o));

  a_r4_r5_dual_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && stat_dual_o) |-> (mem_bank_o == (req_addr_i[WIN_W-1] ^ stat_swap_o)));

  a_r3_single_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !stat_dual_o) |-> (mem_bank_o == req_addr_i[WIN_W-1]));

  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (mem_offset_o == req_addr_i[OW-1:0]));

  a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (next_swap_o == prev_q));

  a_r9_ready_follow: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> (req_ready_o == mem_ready_i));

endmodule

bind dbank_remap dbank_remap_chk #(.AW(AW), .BASE_ADDR(BASE_ADDR), .WIN_BYTES(WIN_BYTES)) chk_i (.*);

// File: tb/dbank_remap_tb_top.sv
module dbank_remap_tb_top;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h0800_0000;
  localparam int WIN = 524288;
  localparam int HALF = WIN / 2;
  localparam int OW = $clog2(WIN) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dual = 1'b0, cfg_swap = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic mem_ready = 1'b0;
  logic swreq_valid = 1'b0;
  logic [1:0] swreq_sel = 2'b00;
  logic req_ready, req_err, mem_valid, mem_bank, next_swap, stat_dual, stat_swap;
  logic [OW-1:0] mem_offset;

  int n_chk = 0, n_fail = 0;
  bit mode_dual, mode_swap;

  typedef struct {
    string tag;
    logic mv, bank, err, rdy;
    logic [OW-1:0] off;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  dbank_remap #(.AW(AW), .BASE_ADDR(BASE), .WIN_BYTES(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dual_i(cfg_dual), .cfg_swap_i(cfg_swap),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .req_err_o(req_err), .mem_valid_o(mem_valid), .mem_bank_o(mem_bank),
    .mem_offset_o(mem_offset), .mem_ready_i(mem_ready),
    .swreq_valid_i(swreq_valid), .swreq_sel_i(swreq_sel), .next_swap_o(next_swap),
    .stat_dual_o(stat_dual), .stat_swap_o(stat_swap));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic [AW-1:0] a, logic rdy);
    item_t it;
    bit inw;
    logic [AW-1:0] loc;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; mem_ready = rdy;
    inw = (a >= BASE) && (a < BASE + WIN);
    loc = a - BASE;
    it.tag = tag;
    it.mv = inw;
    it.err = !inw;
    it.rdy = inw ? rdy : 1'b1;
    it.bank = mode_dual ? ((loc >= HALF) ^ mode_swap) : (loc >= HALF);
    it.off = OW'(loc % HALF);
    exp_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, {31'b0, mem_valid}, {31'b0, it.mv});
        check(it.tag, {31'b0, req_err}, {31'b0, it.err});
        check(it.tag, {31'b0, req_ready}, {31'b0, it.rdy});
        if (it.mv) begin
          check(it.tag, {31'b0, mem_bank}, {31'b0, it.bank});
          check({it.tag, "/R6"}, 32'(mem_offset), 32'(it.off));
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset(bit d, bit s);
    @(negedge clk);
    rst_n = 1'b0; cfg_dual = d; cfg_swap = s; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    #5;
    check("R9 reset no fwd", {30'b0, mem_valid, req_ready}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mode_dual = d; mode_swap = s;
    cfg_dual = ~d; cfg_swap = ~s;
    #5;
    check("R1 dual latched", {31'b0, stat_dual}, {31'b0, d});
    check("R1 swap latched", {31'b0, stat_swap}, {31'b0, s});
    check("R8 next after reset", {31'b0, next_swap}, {31'b0, s});
  endtask

  task automatic swreq(bit [1:0] sel);
    @(negedge clk);
    swreq_valid = 1'b1; swreq_sel = sel;
    @(negedge clk);
    swreq_valid = 1'b0;
    #5;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    bit nxt;
    do_reset(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    #5;
    check("R1 cfg change ignored", {30'b0, stat_dual, stat_swap}, {30'b0, 2'b01});
    access("R3 single base", BASE, 1'b1);
    access("R3 single mid", BASE + HALF, 1'b1);
    access("R3 single last", BASE + WIN - 4, 1'b1);
    access("R9 not ready", BASE + 32'h100, 1'b0);
    access("R2 below base", BASE - 4, 1'b0);
    access("R2 past end", BASE + WIN, 1'b0);
    idle();

    do_reset(1'b1, 1'b0);
    access("R4 low half", BASE + 32'h40, 1'b1);
    access("R4 upper half", BASE + HALF + 32'h40, 1'b1);
    access("R4 last byte", BASE + WIN - 1, 1'b1);
    idle();
    swreq(2'b10);
    check("R7 reserved ignored", {31'b0, next_swap}, 32'd0);
    swreq(2'b01);
    check("R7 select bank2", {31'b0, next_swap}, 32'd1);
    access("R7 mapping unmoved", BASE, 1'b1);
    idle();
    check("R7 swap status unmoved", {31'b0, stat_swap}, 32'd0);
    swreq(2'b00);
    check("R8 second write ignored", {31'b0, next_swap}, 32'd1);

    nxt = next_swap;
    do_reset(1'b1, nxt);
    check("R10 swap applied", {31'b0, stat_swap}, 32'd1);
    access("R10 R5 base is bank2", BASE, 1'b1);
    access("R5 upper is bank1", BASE + HALF, 1'b1);
    access("R5 last lower", BASE + HALF - 4, 1'b0);
    access("R2 far away", 32'h2000_0000, 1'b1);
    idle();
    swreq(2'b00);
    check("R8 new session write", {31'b0, next_swap}, 32'd0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule